// File: doc/BRIEF.md
# Depth-Cascadable FIFO Slice

This block is one slice of a first-in/first-out buffer. Identical slices are chained in a ring to make a deeper buffer. All slices share the write strobe, the read strobe, the reset and the 9-bit data buses. No slice decodes an address. A slice stores a word only while it holds the write token, and returns a word only while it holds the read token. When a slice accesses its last physical location, it hands the matching token to the next slice in the ring with a one-clock pulse on a dedicated expansion line.

The first-load input chooses which slice owns both tokens after reset. Each slice has its own active-low empty and full flags. Logic outside the slice forms the chain flags with an OR of the per-slice flags, so a chain flag asserts only when every slice asserts its own. The strobes are asynchronous and active low. Each slice brings them into its clock domain and acts on their falling edges.

The token logic is a two-state machine, instantiated once for the write side and once for the read side:
- **TK_WAIT**: the slice does not hold the token and ignores the strobe.
- **TK_OWN**: the slice holds the token and serves the strobe.

The transitions are:
- **reset → TK_OWN** when first-load is low, and **reset → TK_WAIT** otherwise.
- **TK_WAIT → TK_OWN** on an expansion-in pulse.
- **TK_OWN → TK_WAIT** on an access to the last location. This transition also emits the expansion-out pulse.

Top module: `fifo_slice`

## Requirements
- R1: While reset is low, every slice clears both pointers to location 0 and its occupancy to zero, so `empty_n` is 0 and `full_n` is 1 for any level of `first_load_n`. Both tokens start only in the slice whose `first_load_n` is low.
- R2: Each falling edge of `wr_n` is seen through a `SYNC_STAGES`-flop synchroniser and acts two clocks after it is sampled. When it acts, the slice holding the write token, if not full, stores `din` at its write pointer and advances that pointer.
- R3: Each falling edge of `rd_n` goes through the same synchroniser. When it acts, the slice holding the read token, if not empty, places the oldest word on `dout`. It raises `dout_oe` until the synchronised `rd_n` is high again.
- R4: A write to location `DEPTH-1` releases the write token, wraps the write pointer to 0 and drives `exp_wr_out` high for exactly one clock.
- R5: A read from location `DEPTH-1` releases the read token, wraps the read pointer to 0 and drives `exp_rd_out` high for exactly one clock.
- R6: A one-clock pulse on `exp_wr_in` or on `exp_rd_in` gives the slice the matching token. The next access of that kind uses location 0.
- R7: `full_n` is 0 exactly while the slice holds `DEPTH` words. A write strobe is then ignored.
- R8: `empty_n` is 0 exactly while the slice holds no word. A read strobe is then ignored, and `dout_oe` stays 0.
- R9: A slice without the relevant token leaves its pointers, occupancy and flags unchanged on a strobe, and keeps `dout_oe` at 0. While `dout_oe` is 0, `dout` is all zeros.
- R10: In a ring of slices, words come out in the order they were written, across slice boundaries.
- R11: A read and a write that act on the same clock edge are both carried out. When they hit one slice, its occupancy is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slice clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| first_load_n | input | 1 | Low marks the slice that owns both tokens after reset |
| wr_n | input | 1 | Shared asynchronous write strobe; acts on its falling edge |
| rd_n | input | 1 | Shared asynchronous read strobe; acts on its falling edge |
| din | input | WIDTH | Write data |
| exp_wr_in | input | 1 | Write-token pulse from the previous slice |
| exp_rd_in | input | 1 | Read-token pulse from the previous slice |
| exp_wr_out | output | 1 | Write-token pulse to the next slice |
| exp_rd_out | output | 1 | Read-token pulse to the next slice |
| dout | output | WIDTH | Read data; zero while not driving |
| dout_oe | output | 1 | High while the slice drives `dout` |
| empty_n | output | 1 | Low when the slice holds no word |
| full_n | output | 1 | Low when the slice holds `DEPTH` words |

## Verification
A read and a write can act on the same clock edge. They may hit one slice, or two slices when the tokens sit apart. The bench provokes this by pulling both strobes low in the same clock period. It does so with data already buffered, and also with the chain empty, where the write must land and the read must be dropped. It judges the result from which slice raises its output enable, the word returned, and the chain flags after both strobes are released, all against an occupancy model kept in the bench.

// File: rtl/fifo_slice_pkg.sv
package fifo_slice_pkg;
    // Ownership state of one token (write or read) inside a slice.
    typedef enum logic {
        TK_WAIT = 1'b0,
        TK_OWN  = 1'b1
    } tok_state_t;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic lvl_n
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], strobe_n};
        end
    end

    assign lvl_n = chain_q[STAGES-1];
endmodule

// File: rtl/token_ctrl.sv
module token_ctrl
    import fifo_slice_pkg::*;
#(
    parameter  int DEPTH = 256,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          first_n,
    input  logic          strobe_lvl_n,
    input  logic          room,
    input  logic          xin,
    output logic [AW-1:0] ptr,
    output logic          go,
    output logic          own,
    output logic          xout
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    tok_state_t state_q, state_d;
    logic       prev_q;
    logic       req;
    logic       at_last;

    assign req     = prev_q & ~strobe_lvl_n;
    assign at_last = (ptr == LAST);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= first_n ? TK_WAIT : TK_OWN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TK_WAIT: if (xin)           state_d = TK_OWN;
            TK_OWN:  if (go && at_last) state_d = TK_WAIT;
            default:                    state_d = TK_WAIT;
        endcase
    end

    // Outputs
    always_comb begin
        own = (state_q == TK_OWN);
        go  = own && req && room;
    end

    // Pointer, edge detector and hand-off pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            ptr    <= '0;
            xout   <= 1'b0;
        end else begin
            prev_q <= strobe_lvl_n;
            xout   <= go && at_last;
            if (go) begin
                ptr <= at_last ? '0 : ptr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/slice_ram.sv
module slice_ram #(
    parameter  int WIDTH = 9,
    parameter  int DEPTH = 256,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
        if (re) begin
            rdata <= cells[raddr];
        end
    end
endmodule

// File: rtl/fifo_slice.sv
module fifo_slice #(
    parameter int WIDTH       = 9,
    parameter int DEPTH       = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             first_load_n,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic [WIDTH-1:0] din,
    input  logic             exp_wr_in,
    input  logic             exp_rd_in,
    output logic             exp_wr_out,
    output logic             exp_rd_out,
    output logic [WIDTH-1:0] dout,
    output logic             dout_oe,
    output logic             empty_n,
    output logic             full_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

    logic             wr_lvl_n, rd_lvl_n;
    logic [CW-1:0]    count_q;
    logic             wr_room, rd_room;
    logic [AW-1:0]    wptr, rptr;
    logic             wr_go, rd_go, wr_own, rd_own;
    logic [WIDTH-1:0] rd_word;
    logic             oe_q;

    strobe_sync #(.STAGES(SYNC_STAGES)) u_wsync (
        .clk(clk), .rst_n(rst_n), .strobe_n(wr_n), .lvl_n(wr_lvl_n)
    );
    strobe_sync #(.STAGES(SYNC_STAGES)) u_rsync (
        .clk(clk), .rst_n(rst_n), .strobe_n(rd_n), .lvl_n(rd_lvl_n)
    );

    assign wr_room = (count_q != CNT_FULL);
    assign rd_room = (count_q != '0);

    token_ctrl #(.DEPTH(DEPTH)) u_wtok (
        .clk(clk), .rst_n(rst_n), .first_n(first_load_n),
        .strobe_lvl_n(wr_lvl_n), .room(wr_room), .xin(exp_wr_in),
        .ptr(wptr), .go(wr_go), .own(wr_own), .xout(exp_wr_out)
    );
    token_ctrl #(.DEPTH(DEPTH)) u_rtok (
        .clk(clk), .rst_n(rst_n), .first_n(first_load_n),
        .strobe_lvl_n(rd_lvl_n), .room(rd_room), .xin(exp_rd_in),
        .ptr(rptr), .go(rd_go), .own(rd_own), .xout(exp_rd_out)
    );

    slice_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
        .clk(clk), .we(wr_go), .waddr(wptr), .wdata(din),
        .re(rd_go), .raddr(rptr), .rdata(rd_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            unique case ({wr_go, rd_go})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q <= 1'b0;
        end else if (rd_go) begin
            oe_q <= 1'b1;
        end else if (rd_lvl_n) begin
            oe_q <= 1'b0;
        end
    end

    assign dout    = oe_q ? rd_word : '0;
    assign dout_oe = oe_q;
    assign empty_n = rd_room;
    assign full_n  = wr_room;
endmodule

// File: rtl/fifo_slice_chk.sv
module fifo_slice_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_go,
    input logic rd_go,
    input logic wr_own,
    input logic rd_own,
    input logic exp_wr_out,
    input logic exp_rd_out,
    input logic dout_oe,
    input logic empty_n,
    input logic full_n
);
    p_flags_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(!empty_n && !full_n));
    p_no_write_when_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |-> !wr_go);
    p_no_read_when_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_n |-> !rd_go);
    p_read_raises_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |=> dout_oe);
    p_wr_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        exp_wr_out |=> !exp_wr_out);
    p_wr_token_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
        exp_wr_out |-> !wr_own);
    p_rd_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        exp_rd_out |=> !exp_rd_out);
    p_rd_token_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
        exp_rd_out |-> !rd_own);
    p_oe_needs_token_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_oe) |-> $past(rd_own));
endmodule

bind fifo_slice fifo_slice_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .rd_go(rd_go),
    .wr_own(wr_own), .rd_own(rd_own), .exp_wr_out(exp_wr_out),
    .exp_rd_out(exp_rd_out), .dout_oe(dout_oe),
    .empty_n(empty_n), .full_n(full_n)
);

// File: tb/fifo_slice_test.sv
module fifo_slice_test;
    localparam int N   = 3;
    localparam int D   = 4;
    localparam int CAP = N * D;
    localparam int NV  = 34;

    // {op[1:0], data[8:0]}; op 01 write, 10 read, 11 read and write together
    localparam logic [10:0] VEC [NV] = '{
        11'h211, 11'h222, 11'h233, 11'h244, 11'h255, 11'h266, 11'h277,
        11'h288, 11'h299, 11'h2AA, 11'h2BB, 11'h2CC, 11'h2DD,
        11'h400, 11'h400, 11'h400, 11'h400, 11'h400, 11'h400, 11'h400,
        11'h400, 11'h400, 11'h400, 11'h400, 11'h400, 11'h400,
        11'h3E1, 11'h3F2, 11'h701, 11'h702, 11'h703,
        11'h400, 11'h400, 11'h400
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_n = 1'b1;
    logic       rd_n = 1'b1;
    logic [8:0] din = '0;
    logic       xw [N];
    logic       xr [N];
    logic [8:0] dq [N];
    logic [N-1:0] oe_v, empty_v, full_v;
    logic [8:0] dout_or;
    logic       comp_empty_n, comp_full_n;
    int         checks = 0;
    int         fails  = 0;
    int         wp0 = 0;
    int         rp0 = 0;
    logic [8:0] model [CAP];
    int         head = 0;
    int         cnt  = 0;

    always #10 clk = ~clk;

    for (genvar i = 0; i < N; i++) begin : uut
        fifo_slice #(.WIDTH(9), .DEPTH(D), .SYNC_STAGES(2)) slice (
            .clk(clk), .rst_n(rst_n), .first_load_n(i != 0),
            .wr_n(wr_n), .rd_n(rd_n), .din(din),
            .exp_wr_in(xw[(i + N - 1) % N]), .exp_rd_in(xr[(i + N - 1) % N]),
            .exp_wr_out(xw[i]), .exp_rd_out(xr[i]),
            .dout(dq[i]), .dout_oe(oe_v[i]),
            .empty_n(empty_v[i]), .full_n(full_v[i])
        );
    end

    always_comb begin
        dout_or = '0;
        for (int i = 0; i < N; i++) dout_or = dout_or | dq[i];
    end
    assign comp_empty_n = |empty_v;
    assign comp_full_n  = |full_v;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp0 <= 0;
            rp0 <= 0;
        end else begin
            if (xw[0]) wp0 <= wp0 + 1;
            if (xr[0]) rp0 <= rp0 + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic dw, input logic dr, input logic [8:0] d,
                          output int n_oe, output logic [8:0] q);
        @(negedge clk);
        din  = d;
        wr_n = ~dw;
        rd_n = ~dr;
        repeat (5) @(negedge clk);
        n_oe = $countones(oe_v);
        q    = dout_or;
        wr_n = 1'b1;
        rd_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R10 actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        int n_oe;
        logic [8:0] q;
        logic dw, dr;
        logic can_r, can_w;
        do_reset();
        // R1: reset state on every slice
        chk("R1 empty_n", int'(empty_v), 0);
        chk("R1 full_n", int'(full_v), (1 << N) - 1);
        chk("R1 dout_oe", int'(oe_v), 0);

        for (int v = 0; v < NV; v++) begin
            dw = VEC[v][9];
            dr = VEC[v][10];
            can_r = dr && (cnt > 0);
            can_w = dw && (cnt < CAP);
            access(dw, dr, VEC[v][8:0], n_oe, q);
            if (dr) begin
                if (can_r) begin
                    chk(dw ? "R11 read oe" : "R3 read oe", n_oe, 1);
                    chk(dw ? "R11 read data" : "R10 read order", int'(q), int'(model[head]));
                    head = (head + 1) % CAP;
                    cnt--;
                end else begin
                    chk("R8 ignored read oe", n_oe, 0);
                end
            end
            if (can_w) begin
                model[(head + cnt) % CAP] = VEC[v][8:0];
                cnt++;
            end
            chk("R8 chain empty flag", int'(comp_empty_n), int'(cnt != 0));
            chk("R7 chain full flag", int'(comp_full_n), int'(cnt != CAP));
        end

        // R1 again: reset in mid-operation
        do_reset();
        chk("R1 empty_n after reset", int'(empty_v), 0);
        chk("R1 full_n after reset", int'(full_v), (1 << N) - 1);

        // R2, R4, R7, R9: first-load slice takes the first DEPTH writes
        for (int k = 0; k < D; k++) access(1'b1, 1'b0, 9'h0A0 + 9'(k), n_oe, q);
        chk("R7 slice0 full", int'(full_v[0]), 0);
        chk("R9 slice1 untouched", int'(empty_v[1]), 0);
        chk("R9 slice2 untouched", int'(empty_v[2]), 0);
        chk("R4 write hand-off pulses", wp0, 1);

        // R6: next write lands in slice1
        access(1'b1, 1'b0, 9'h155, n_oe, q);
        chk("R6 slice1 filled", int'(empty_v[1]), 1);
        chk("R7 full write ignored slice0", int'(full_v[0]), 0);

        // R3, R5, R10: read back in order and across the boundary
        for (int k = 0; k < D; k++) begin
            access(1'b0, 1'b1, 9'h000, n_oe, q);
            chk("R3 slice0 data", int'(q), int'(9'h0A0) + k);
            chk("R9 single driver", n_oe, 1);
        end
        chk("R5 read hand-off pulses", rp0, 1);
        chk("R8 slice0 drained", int'(empty_v[0]), 0);
        access(1'b0, 1'b1, 9'h000, n_oe, q);
        chk("R10 cross-slice data", int'(q), int'(9'h155));
        chk("R8 chain empty", int'(comp_empty_n), 0);

        // R11 with R8: both strobes on an empty chain
        access(1'b1, 1'b1, 9'h1AB, n_oe, q);
        chk("R8 read dropped when empty", n_oe, 0);
        chk("R11 write landed", int'(comp_empty_n), 1);
        access(1'b0, 1'b1, 9'h000, n_oe, q);
        chk("R2 stored word", int'(q), int'(9'h1AB));

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule